// File: doc/BRIEF.md
# Bus Idle-Gap Enforcer

This block sits between a processor's access request port and the external memory bus sequencer. It keeps the bus idle for a minimum number of bus clock cycles between consecutive access cycles. The requester raises a request with a direction and a continuation flag and holds it. The block grants it once the bus is free and enough idle cycles have passed since the previous access completed. The sequencer then runs the access and pulses a completion strobe.

The required gap is the larger of two values. One is a programmed idle setting of 0, 1, 2 or 4 cycles. The other is a built-in floor that depends on four things: the direction of the previous access against the new one, whether the new access continues a split or burst transfer, a wait-mode bit, and the core-to-bus clock ratio. The idle setting, the wait-mode bit and the ratio arrive as static configuration inputs. Only one access is outstanding at a time.

Top module: `idle_gap_ctrl`

## Requirements
- R1: After reset, reqGrant and busBusy are 0. A request made before any access has completed is granted in the cycle it is first presented.
- R2: reqGrant is never high while busBusy is high. busBusy rises in the cycle after a grant and falls in the cycle after accDone is seen while busy.
- R3: For a non-continuation write after a read, the gap is max(idle value, 3) when ratioSel is 0, 1 or 2 (4:1, 3:1, 2:1). It is max(idle value, 4) when ratioSel is 3 (1:1).
- R4: With waitMode=1 and idleSel=0, the gap for non-continuation accesses is 1 for read after read, 0 for write after write and 0 for read after write.
- R5: With waitMode=0 and idleSel=0, every non-continuation transition other than write-after-read needs a gap of 1.
- R6: idleSel encodes the idle value as 0→0, 1→1, 2→2, 3→4 cycles. The gap is never below that value. With idleSel=3 every gap is exactly 4.
- R7: For a continuation access (reqCont=1), the gap is 0 when waitMode=1 and idleSel=0. Otherwise it is max(1, idle value), whatever the directions and the ratio.
- R8: ratioSel affects only the write-after-read floor. Other transitions get the same gap at every ratio.
- R9: A gap counts bus cycles after the accDone cycle. With accDone in cycle D, a request first presented in cycle Q is granted in cycle max(D+1+gap, Q). A request arriving after the gap has elapsed is granted in the same cycle.
- R10: reqGrant is high only while reqValid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| waitMode | input | 1 | Wait-mode configuration bit |
| idleSel | input | 2 | Idle setting code: 0,1,2 → 0,1,2 cycles; 3 → 4 cycles |
| ratioSel | input | 2 | Core-to-bus clock ratio: 0=4:1, 1=3:1, 2=2:1, 3=1:1 |
| reqValid | input | 1 | Access request, held until granted |
| reqWrite | input | 1 | Requested access is a write (0 = read) |
| reqCont | input | 1 | Requested access continues a split or burst transfer |
| reqGrant | output | 1 | Request granted this cycle (combinational) |
| accDone | input | 1 | Sequencer reports the granted access complete |
| busBusy | output | 1 | An access is outstanding |

## Verification
The grant is combinational. It is due in cycle max(D+1+gap, Q), where D is the cycle in which accDone was driven and Q is the first cycle of the request. busBusy is due one cycle after a grant and clears one cycle after accDone. The bench drives inputs on the falling edge and samples 1 ns later. It numbers cycles by rising edges and compares the grant cycle with the expected one. While an access is outstanding, the bench holds reqValid high and checks in every busy cycle that no grant appears.

// File: rtl/idle_gap_pkg.sv
`timescale 1ns/1ps
package idle_gap_pkg;

  localparam int GAP_MAX = 4;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  typedef logic [GAP_W-1:0] gap_t;

  typedef enum logic [1:0] {
    RATIO_4TO1 = 2'd0,
    RATIO_3TO1 = 2'd1,
    RATIO_2TO1 = 2'd2,
    RATIO_1TO1 = 2'd3
  } ratio_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdle;   // previous access completed: restart idle count
    logic stepIdle;  // bus idle this cycle: advance idle count
    logic capDir;    // grant: remember direction of access in flight
  } idleStrobe_t;

  function automatic gap_t calcGap(input logic prevWr, input logic nextWr,
                                   input logic cont, input logic wm,
                                   input logic [1:0] idleSel, input ratio_e ratio);
    gap_t idleVal;
    gap_t floorVal;
    idleVal = (idleSel == 2'd3) ? gap_t'(GAP_MAX) : gap_t'(idleSel);
    if (cont)
      floorVal = (wm && idleSel == 2'd0) ? gap_t'(0) : gap_t'(1);
    else if (!prevWr && nextWr)
      floorVal = (ratio == RATIO_1TO1) ? gap_t'(4) : gap_t'(3);
    else
      floorVal = (wm && (prevWr || nextWr)) ? gap_t'(0) : gap_t'(1);
    return (idleVal > floorVal) ? idleVal : floorVal;
  endfunction

endpackage

// File: rtl/idle_gap_fsm.sv
`timescale 1ns/1ps
module idle_gap_fsm
  import idle_gap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        accDone,
  input  logic        gapMet,
  output logic        reqGrant,
  output logic        busBusy,
  output idleStrobe_t strobe
);

  logic busyQ;
  logic hasPrevQ;

  always_comb begin
    reqGrant        = reqValid && !busyQ && (!hasPrevQ || gapMet);
    strobe.clrIdle  = busyQ && accDone;
    strobe.stepIdle = !busyQ && hasPrevQ;
    strobe.capDir   = reqGrant;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      hasPrevQ <= 1'b0;
    end else if (reqGrant) begin
      busyQ <= 1'b1;
    end else if (busyQ && accDone) begin
      busyQ    <= 1'b0;
      hasPrevQ <= 1'b1;
    end
  end

  assign busBusy = busyQ;

endmodule

// File: rtl/idle_gap_dp.sv
`timescale 1ns/1ps
module idle_gap_dp
  import idle_gap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  idleStrobe_t strobe,
  input  logic        reqWrite,
  input  logic        reqCont,
  input  logic        waitMode,
  input  logic [1:0]  idleSel,
  input  ratio_e      ratio,
  output logic        gapMet
);

  localparam gap_t GAP_SAT = gap_t'(GAP_MAX);

  gap_t idleCnt;
  gap_t needGap;
  logic prevWrQ;

  always_comb begin
    needGap = calcGap(prevWrQ, reqWrite, reqCont, waitMode, idleSel, ratio);
    gapMet  = (idleCnt >= needGap);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
      prevWrQ <= 1'b0;
    end else begin
      if (strobe.clrIdle)
        idleCnt <= '0;
      else if (strobe.stepIdle && idleCnt < GAP_SAT)
        idleCnt <= idleCnt + gap_t'(1);
      if (strobe.capDir)
        prevWrQ <= reqWrite;
    end
  end

endmodule

// File: rtl/idle_gap_ctrl.sv
`timescale 1ns/1ps
module idle_gap_ctrl
  import idle_gap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       waitMode,
  input  logic [1:0] idleSel,
  input  logic [1:0] ratioSel,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqCont,
  output logic       reqGrant,
  input  logic       accDone,
  output logic       busBusy
);

  idleStrobe_t strobe;
  logic        gapMet;
  ratio_e      ratio;

  assign ratio = ratio_e'(ratioSel);

  idle_gap_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .accDone  (accDone),
    .gapMet   (gapMet),
    .reqGrant (reqGrant),
    .busBusy  (busBusy),
    .strobe   (strobe)
  );

  idle_gap_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqWrite (reqWrite),
    .reqCont  (reqCont),
    .waitMode (waitMode),
    .idleSel  (idleSel),
    .ratio    (ratio),
    .gapMet   (gapMet)
  );

endmodule

// File: rtl/idle_gap_chk.sv
`timescale 1ns/1ps
module idle_gap_chk (
  input logic       clk,
  input logic       rstN,
  input logic       waitMode,
  input logic [1:0] idleSel,
  input logic       reqValid,
  input logic       reqGrant,
  input logic       accDone,
  input logic       busBusy
);

  // R2
  busy_blocks_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    busBusy |-> !reqGrant);

  // R2
  grant_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |=> busBusy);

  // R2
  done_frees_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && accDone) |=> !busBusy);

  // R10
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |-> reqValid);

  // R6
  idle4_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && accDone && idleSel == 2'd3) |=> (idleSel != 2'd3 || !reqGrant));

  // R5
  nowait_min_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && accDone && !waitMode) |=> (waitMode || !reqGrant));

endmodule

bind idle_gap_ctrl idle_gap_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .waitMode (waitMode),
  .idleSel  (idleSel),
  .reqValid (reqValid),
  .reqGrant (reqGrant),
  .accDone  (accDone),
  .busBusy  (busBusy)
);

// File: tb/idle_gap_ctrl_tb.sv
`timescale 1ns/1ps
module idle_gap_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       waitMode = 1'b0;
  logic [1:0] idleSel = 2'd0;
  logic [1:0] ratioSel = 2'd0;
  logic       reqValid = 1'b0;
  logic       reqWrite = 1'b0;
  logic       reqCont = 1'b0;
  logic       reqGrant;
  logic       accDone = 1'b0;
  logic       busBusy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int doneCyc = 0;
  bit hasPrev = 1'b0;
  bit prevWr = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  idle_gap_ctrl u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .waitMode (waitMode),
    .idleSel  (idleSel),
    .ratioSel (ratioSel),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqCont  (reqCont),
    .reqGrant (reqGrant),
    .accDone  (accDone),
    .busBusy  (busBusy)
  );

  // expected gap, written from the requirements
  function automatic int expGap(bit pw, bit nw, bit cont, bit wm, int idle, int ratio);
    int iv;
    iv = (idle == 3) ? 4 : idle;
    if (iv == 4) return 4;                                   // R6
    if (cont) return (wm && iv == 0) ? 0 : ((iv < 1) ? 1 : iv); // R7
    if (!pw && nw) return (ratio == 3) ? 4 : 3;              // R3
    if (iv == 2) return 2;
    if (iv == 1) return 1;
    if (!wm) return 1;                                       // R5
    return (!pw && !nw) ? 1 : 0;                             // R4
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runAccess(bit wr, bit cont, int delay, bit wm, int idle,
                           int ratio, int lat, string req);
    int firstQ;
    int want;
    int g;
    int n;
    repeat (delay) begin
      @(negedge clk);
      accDone = 1'b0; reqValid = 1'b0;
      waitMode = wm; idleSel = 2'(idle); ratioSel = 2'(ratio);
    end
    @(negedge clk);
    accDone = 1'b0;
    waitMode = wm; idleSel = 2'(idle); ratioSel = 2'(ratio);
    reqValid = 1'b1; reqWrite = wr; reqCont = cont;
    firstQ = cyc;
    n = 0;
    #1;
    while (!reqGrant && n < 40) begin
      @(negedge clk);
      n++;
      #1;
    end
    g = cyc;
    if (hasPrev) begin
      want = doneCyc + 1 + expGap(prevWr, wr, cont, wm, idle, ratio);
      if (firstQ > want) want = firstQ;
    end else begin
      want = firstQ;
    end
    check(reqGrant && g == want, req, g, want);
    prevWr = wr;
    repeat (lat) begin
      @(negedge clk);
      reqValid = 1'b1;
      #1;
      // R2: busy and no grant while access outstanding
      check(busBusy && !reqGrant, "R2", {busBusy, reqGrant}, 2);
    end
    @(negedge clk);
    reqValid = 1'b1;
    accDone = 1'b1;
    doneCyc = cyc;
    hasPrev = 1'b1;
    #1;
    check(busBusy && !reqGrant, "R2", {busBusy, reqGrant}, 2);
  endtask

  initial begin
    void'($urandom(32'h5eed_1d1e));
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(!reqGrant && !busBusy, "R1", {reqGrant, busBusy}, 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!reqGrant && !busBusy, "R1", {reqGrant, busBusy}, 0);

    // R1: first request granted at once
    runAccess(0, 0, 2, 1, 0, 0, 1, "R1");
    // R4: wait mode, idle 0
    runAccess(0, 0, 0, 1, 0, 0, 0, "R4");  // RR -> 1
    runAccess(1, 0, 0, 1, 0, 0, 2, "R3");  // WR -> 3
    runAccess(1, 0, 0, 1, 0, 0, 0, "R4");  // WW -> 0
    runAccess(0, 0, 0, 1, 0, 0, 1, "R4");  // RW -> 0
    // R3: ratios
    runAccess(1, 0, 0, 1, 1, 3, 0, "R3");  // 1:1 -> 4
    runAccess(0, 0, 0, 0, 0, 0, 0, "R5");  // RW -> 1
    runAccess(1, 0, 0, 0, 2, 1, 0, "R3");  // 3:1 -> 3
    runAccess(1, 0, 0, 0, 0, 2, 1, "R5");  // WW -> 1
    runAccess(0, 0, 0, 0, 0, 3, 0, "R8");  // RW at 1:1 -> 1
    runAccess(0, 0, 0, 1, 0, 3, 0, "R8");  // RR at 1:1 -> 1
    // R6
    runAccess(0, 0, 0, 1, 2, 0, 0, "R6");  // RR -> 2
    runAccess(0, 0, 0, 1, 3, 0, 0, "R6");  // RR -> 4
    runAccess(1, 0, 0, 1, 3, 0, 0, "R6");  // WR -> 4
    // R7: continuation
    runAccess(1, 1, 0, 1, 0, 0, 0, "R7");  // cont -> 0
    runAccess(0, 0, 0, 1, 0, 3, 0, "R4");
    runAccess(1, 1, 0, 1, 0, 3, 0, "R7");  // cont after read -> 0
    runAccess(1, 1, 0, 0, 0, 3, 0, "R7");  // -> 1
    runAccess(1, 1, 0, 1, 2, 3, 0, "R7");  // -> 2
    runAccess(1, 1, 0, 1, 3, 3, 0, "R7");  // -> 4
    // R9: late request granted at once
    runAccess(0, 0, 0, 1, 0, 0, 0, "R4");
    runAccess(1, 0, 5, 1, 0, 0, 0, "R9");  // gap 3 elapsed
    runAccess(1, 0, 2, 0, 3, 0, 0, "R9");  // gap 4, waits

    for (int i = 0; i < 400; i++) begin
      runAccess($urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(6, 0),
                $urandom_range(1, 0), $urandom_range(3, 0), $urandom_range(3, 0),
                $urandom_range(3, 0), "R9");
    end

    @(negedge clk);
    accDone = 1'b0; reqValid = 1'b0;
    #1;
    // R10: no grant without request
    check(!reqGrant, "R10", reqGrant, 0);
    repeat (6) @(negedge clk);
    #1;
    check(!reqGrant && !busBusy, "R10", {reqGrant, busBusy}, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule